// File: doc/BRIEF.md
# Masked Content Addressable Memory

This block is a searchable word store of 256 entries, each 64 bits wide, with a per-entry occupied flag. A search key register and two independent don't-care registers are loaded through the same synchronous port that writes and reads the store. On every cycle the key is compared, in parallel, against every occupied entry under whichever don't-care register is currently selected. The block reports whether any entry agreed and the index of the lowest-numbered one that did.

Entries can be written at an explicit index, at the lowest unoccupied index, or over the lowest-numbered agreeing entry. Reads return the key, either don't-care register, the entry at an explicit index, or the lowest agreeing entry. The block also reports the lowest unoccupied index and raises a flag once every entry is occupied. All commands arrive as a 4-bit operation code with a 64-bit data word and an 8-bit index, one command per clock.

Top module: `cam_masked`

## Requirements
- R1: After a synchronous reset no entry is occupied, `free_addr` is 0, `full` and `hit` are 0, `rdata` is 0, the key and both don't-care registers are 0, and don't-care register A is selected.
- R2: Operation 1 loads the key, 2 loads don't-care A and 3 loads don't-care B from `wdata`. Operations 7, 8 and 9 read them back, and the value appears on `rdata` after the next rising edge and holds until the next read operation.
- R3: Operation 4 writes `wdata` to the entry at `addr` and marks it occupied, even when the store is full. Operation 10 returns that entry on `rdata` one cycle later, or 0 if the entry is unoccupied.
- R4: `free_addr` always equals the lowest unoccupied index. Operation 5 writes `wdata` there and marks it occupied.
- R5: `full` is 1 exactly when all entries are occupied, and `free_addr` is then 0. An operation 5 issued while full changes no entry.
- R6: An entry agrees with the key when it is occupied and equal to the key on every bit where the selected don't-care register holds 0. `hit` is 1 when any entry agrees, and `hit_addr` is then the lowest agreeing index. When nothing agrees, `hit_addr` is 0.
- R7: Operation 12 selects don't-care A and operation 13 selects don't-care B for the comparison. The selection persists until changed.
- R8: Operation 6 overwrites the lowest agreeing entry with `wdata`. When no entry agrees, it changes nothing.
- R9: Operation 11 returns the lowest agreeing entry on `rdata` one cycle later, or 0 when no entry agrees.
- R10: `hit`, `hit_addr`, `full` and `free_addr` reflect the operation executed at a rising edge immediately after that edge, one cycle after it was presented.
- R11: Operation 0 and the unused codes 14 and 15 leave every register, entry and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code, one per cycle |
| addr | input | 8 | Entry index for indexed write and read |
| wdata | input | 64 | Data for loads and writes |
| rdata | output | 64 | Registered read result |
| hit | output | 1 | Some occupied entry agrees with the key |
| hit_addr | output | 8 | Lowest agreeing index |
| full | output | 1 | Every entry is occupied |
| free_addr | output | 8 | Lowest unoccupied index |

## Verification
The search is tried with the same value stored at two indices, which distinguishes lowest-index priority from last-written or highest-index priority. It is also tried with a key that differs from entries only in don't-care bits, which shows whether the selected register and not the other one is applied. An all-ones don't-care register makes every occupied entry agree, and a key with no counterpart shows that `hit_addr` falls back to 0. Writes are scattered so that a hole opens below filled indices, the store is then filled completely, and a further write to the next free entry is issued whose data is searched for afterwards to prove it was dropped.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int CAM_DEPTH_DEF = 256;
    localparam int CAM_WIDTH_DEF = 64;
    localparam int CAM_OP_W      = 4;

    typedef enum logic [CAM_OP_W-1:0] {
        OP_NOP     = 4'd0,
        OP_LD_KEY  = 4'd1,
        OP_LD_DCA  = 4'd2,
        OP_LD_DCB  = 4'd3,
        OP_WR_AT   = 4'd4,
        OP_WR_FREE = 4'd5,
        OP_WR_HIT  = 4'd6,
        OP_RD_KEY  = 4'd7,
        OP_RD_DCA  = 4'd8,
        OP_RD_DCB  = 4'd9,
        OP_RD_AT   = 4'd10,
        OP_RD_HIT  = 4'd11,
        OP_SEL_A   = 4'd12,
        OP_SEL_B   = 4'd13
    } cam_op_e;

    typedef enum logic [1:0] {
        WT_NONE, WT_AT, WT_FREE, WT_HIT
    } wr_tgt_e;

    typedef enum logic [2:0] {
        RS_NONE, RS_KEY, RS_DCA, RS_DCB, RS_AT, RS_HIT
    } rd_src_e;

    typedef struct packed {
        wr_tgt_e wr_tgt;
        rd_src_e rd_src;
        logic    ld_key;
        logic    ld_dca;
        logic    ld_dcb;
        logic    sel_a;
        logic    sel_b;
    } cam_cmd_t;

    function automatic cam_cmd_t cam_decode(input logic [CAM_OP_W-1:0] code);
        cam_cmd_t c;
        c = '{wr_tgt: WT_NONE, rd_src: RS_NONE, default: 1'b0};
        case (code)
            OP_LD_KEY:  c.ld_key = 1'b1;
            OP_LD_DCA:  c.ld_dca = 1'b1;
            OP_LD_DCB:  c.ld_dcb = 1'b1;
            OP_WR_AT:   c.wr_tgt = WT_AT;
            OP_WR_FREE: c.wr_tgt = WT_FREE;
            OP_WR_HIT:  c.wr_tgt = WT_HIT;
            OP_RD_KEY:  c.rd_src = RS_KEY;
            OP_RD_DCA:  c.rd_src = RS_DCA;
            OP_RD_DCB:  c.rd_src = RS_DCB;
            OP_RD_AT:   c.rd_src = RS_AT;
            OP_RD_HIT:  c.rd_src = RS_HIT;
            OP_SEL_A:   c.sel_a  = 1'b1;
            OP_SEL_B:   c.sel_b  = 1'b1;
            default:    ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cam_keyregs.sv
module cam_keyregs
    import cam_pkg::*;
#(
    parameter int W = CAM_WIDTH_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  cam_cmd_t     cmd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] key_q,
    output logic [W-1:0] dca_q,
    output logic [W-1:0] dcb_q,
    output logic [W-1:0] care_mask
);

    logic use_b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q   <= '0;
            dca_q   <= '0;
            dcb_q   <= '0;
            use_b_q <= 1'b0;
        end else begin
            if (cmd.ld_key) key_q <= wdata;
            if (cmd.ld_dca) dca_q <= wdata;
            if (cmd.ld_dcb) dcb_q <= wdata;
            if (cmd.sel_a)      use_b_q <= 1'b0;
            else if (cmd.sel_b) use_b_q <= 1'b1;
        end
    end

    // bits that take part in the comparison: 0 in the selected don't-care register
    assign care_mask = use_b_q ? ~dcb_q : ~dca_q;

endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
    parameter int N  = 256,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [AW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = AW'(i);
            end
        end
    end

endmodule

// File: rtl/cam_store.sv
module cam_store
    import cam_pkg::*;
#(
    parameter int W     = CAM_WIDTH_DEF,
    parameter int DEPTH = CAM_DEPTH_DEF,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [W-1:0]     wword,
    input  logic [AW-1:0]    raddr,
    output logic [W-1:0]     rword,
    input  logic [W-1:0]     key,
    input  logic [W-1:0]     care,
    output logic [DEPTH-1:0] agree,
    output logic [DEPTH-1:0] occupied
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            occupied <= '0;
        end else if (we) begin
            occupied[waddr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wword;
    end

    assign rword = occupied[raddr] ? mem[raddr] : '0;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign agree[g] = occupied[g] && (((mem[g] ^ key) & care) == '0);
    end

endmodule

// File: rtl/cam_masked.sv
module cam_masked
    import cam_pkg::*;
#(
    parameter  int DEPTH = CAM_DEPTH_DEF,
    parameter  int WIDTH = CAM_WIDTH_DEF,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CAM_OP_W-1:0] op,
    input  logic [AW-1:0]       addr,
    input  logic [WIDTH-1:0]    wdata,
    output logic [WIDTH-1:0]    rdata,
    output logic                hit,
    output logic [AW-1:0]       hit_addr,
    output logic                full,
    output logic [AW-1:0]       free_addr
);

    cam_cmd_t         cmd;
    logic [WIDTH-1:0] key_q, dca_q, dcb_q, care_mask;
    logic [DEPTH-1:0] agree, valid_q;
    logic             we, free_found;
    logic [AW-1:0]    waddr, raddr;
    logic [WIDTH-1:0] rword;
    logic [WIDTH-1:0] rdata_q;

    assign cmd = cam_decode(op);

    cam_keyregs #(.W(WIDTH)) u_keys (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .wdata     (wdata),
        .key_q     (key_q),
        .dca_q     (dca_q),
        .dcb_q     (dcb_q),
        .care_mask (care_mask)
    );

    cam_store #(.W(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .waddr    (waddr),
        .wword    (wdata),
        .raddr    (raddr),
        .rword    (rword),
        .key      (key_q),
        .care     (care_mask),
        .agree    (agree),
        .occupied (valid_q)
    );

    cam_prio #(.N(DEPTH), .AW(AW)) u_hit_enc (
        .vec   (agree),
        .found (hit),
        .idx   (hit_addr)
    );

    cam_prio #(.N(DEPTH), .AW(AW)) u_free_enc (
        .vec   (~valid_q),
        .found (free_found),
        .idx   (free_addr)
    );

    assign full = ~free_found;

    always_comb begin
        we    = 1'b0;
        waddr = addr;
        unique case (cmd.wr_tgt)
            WT_AT:   begin we = 1'b1;       waddr = addr;      end
            WT_FREE: begin we = free_found; waddr = free_addr; end
            WT_HIT:  begin we = hit;        waddr = hit_addr;  end
            default: ;
        endcase
    end

    assign raddr = (cmd.rd_src == RS_HIT) ? hit_addr : addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            case (cmd.rd_src)
                RS_KEY:  rdata_q <= key_q;
                RS_DCA:  rdata_q <= dca_q;
                RS_DCB:  rdata_q <= dcb_q;
                RS_AT:   rdata_q <= rword;
                RS_HIT:  rdata_q <= hit ? rword : '0;
                default: ;
            endcase
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/cam_masked_chk.sv
module cam_masked_chk #(
    parameter int DEPTH = 256,
    parameter int W     = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       op,
    input logic [W-1:0]     rdata,
    input logic             hit,
    input logic [AW-1:0]    hit_addr,
    input logic             full,
    input logic [AW-1:0]    free_addr,
    input logic [DEPTH-1:0] valid_vec
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (free_addr == '0 && !full && !hit && rdata == '0)); // R1

    AST_FREE_IS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !full |-> !valid_vec[free_addr]); // R4

    AST_FREE_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd5 && !full) |=> valid_vec[$past(free_addr)]); // R4

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
        full |=> (full && free_addr == '0)); // R5

    AST_HIT_OCCUPIED: assert property (@(posedge clk) disable iff (rst)
        hit |-> valid_vec[hit_addr]); // R6

    AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit |-> hit_addr == '0); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd0 || op == 4'd14 || op == 4'd15) |=>
        ($stable(hit) && $stable(hit_addr) && $stable(full) &&
         $stable(free_addr) && $stable(rdata))); // R11

endmodule

bind cam_masked cam_masked_chk #(.DEPTH(DEPTH), .W(WIDTH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .rdata     (rdata),
    .hit       (hit),
    .hit_addr  (hit_addr),
    .full      (full),
    .free_addr (free_addr),
    .valid_vec (valid_q)
);

// File: tb/tb_cam_masked.sv
`timescale 1ns/1ps
module tb_cam_masked;

    localparam int D  = 256;
    localparam int W  = 64;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    op = 4'd0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          hit, full;
    logic [AW-1:0] hit_addr, free_addr;

    always #2 clk = ~clk; // 250 MHz

    cam_masked dut (
        .clk(clk), .rst(rst), .op(op), .addr(addr), .wdata(wdata),
        .rdata(rdata), .hit(hit), .hit_addr(hit_addr),
        .full(full), .free_addr(free_addr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit live  = 0;

    // behavioural reference state
    logic [W-1:0] r_mem [D];
    bit           r_val [D];
    logic [W-1:0] r_key, r_dca, r_dcb, r_rd;
    bit           r_useb;

    function automatic bit r_agree(int i);
        logic [W-1:0] dc;
        dc = r_useb ? r_dcb : r_dca;
        return r_val[i] && (((r_mem[i] ^ r_key) & ~dc) == '0);
    endfunction

    function automatic int r_hit_idx();
        for (int i = 0; i < D; i++) if (r_agree(i)) return i;
        return -1;
    endfunction

    function automatic int r_free_idx();
        for (int i = 0; i < D; i++) if (!r_val[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        int h, f;
        if (rst) begin
            for (int i = 0; i < D; i++) r_val[i] = 0;
            r_key = '0; r_dca = '0; r_dcb = '0; r_rd = '0; r_useb = 0;
        end else begin
            h = r_hit_idx();
            f = r_free_idx();
            case (op)
                4'd1:  r_key = wdata;
                4'd2:  r_dca = wdata;
                4'd3:  r_dcb = wdata;
                4'd4:  begin r_mem[addr] = wdata; r_val[addr] = 1; end
                4'd5:  if (f >= 0) begin r_mem[f] = wdata; r_val[f] = 1; end
                4'd6:  if (h >= 0) r_mem[h] = wdata;
                4'd7:  r_rd = r_key;
                4'd8:  r_rd = r_dca;
                4'd9:  r_rd = r_dcb;
                4'd10: r_rd = r_val[addr] ? r_mem[addr] : '0;
                4'd11: r_rd = (h >= 0) ? r_mem[h] : '0;
                4'd12: r_useb = 0;
                4'd13: r_useb = 1;
                default: ;
            endcase
        end
    end

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // compare against the reference away from the rising edge
    always @(negedge clk) begin
        int h, f;
        if (live && !rst) begin
            h = r_hit_idx();
            f = r_free_idx();
            check("R6 hit", W'(hit), W'(h >= 0));
            check("R6 hit_addr", W'(hit_addr), W'((h >= 0) ? h : 0));
            check("R5 full", W'(full), W'(f < 0));
            check("R4 free_addr", W'(free_addr), W'((f >= 0) ? f : 0));
            check("R2 rdata", rdata, r_rd);
        end
    end

    task automatic issue(logic [3:0] o, logic [AW-1:0] a, logic [W-1:0] d);
        op = o; addr = a; wdata = d;
        @(negedge clk);
        op = 4'd0;
    endtask

    localparam logic [W-1:0] VA = 64'h1111_2222_3333_4444;
    localparam logic [W-1:0] VB = 64'h0000_0000_0000_00A0;
    localparam logic [W-1:0] VC = 64'h0000_0000_0000_00B0;
    localparam logic [W-1:0] VD = 64'hDEAD_BEEF_0000_0001;
    localparam logic [W-1:0] VF = 64'h5555_0000_0000_00B1;
    localparam logic [W-1:0] VG = 64'h7777_0000_0000_0000;
    localparam logic [W-1:0] VH = 64'h0BAD_0000_0000_0000;
    localparam logic [W-1:0] VX = 64'hABCD_0000_0000_0000;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live = 1'b1;
        @(negedge clk);
        check("R1 hit", W'(hit), 0);
        check("R1 free_addr", W'(free_addr), 0);
        check("R1 full", W'(full), 0);
        check("R1 rdata", rdata, 0);

        issue(4'd14, 8'd3, 64'hFFFF);
        issue(4'd15, 8'd3, 64'hFFFF);
        issue(4'd0,  8'd3, 64'hFFFF);
        issue(4'd7, 0, 0);
        check("R11 key untouched", rdata, 0);
        check("R11 no entry written", W'(free_addr), 0);

        issue(4'd4, 8'd5, VA);
        check("R4 free_addr unaffected by indexed write", W'(free_addr), 0);
        issue(4'd10, 8'd5, 0);
        check("R3 read written entry", rdata, VA);
        issue(4'd10, 8'd6, 0);
        check("R3 unoccupied reads zero", rdata, 0);

        issue(4'd5, 0, VB);
        issue(4'd5, 0, VC);
        issue(4'd5, 0, VD);
        issue(4'd5, 0, VA);
        issue(4'd5, 0, VF);
        check("R4 free skips occupied 5", W'(free_addr), 6);
        issue(4'd10, 8'd4, 0);
        check("R4 fifth free write at 4", rdata, VF);

        issue(4'd2, 0, 64'hFF);
        check("R10 hit one cycle after don't-care load", W'(hit_addr), 0);
        issue(4'd8, 0, 0);
        check("R2 read don't-care A", rdata, 64'hFF);
        issue(4'd1, 0, VA);
        check("R10 hit_addr after key load", W'(hit_addr), 3);
        check("R6 lowest of two agreeing", W'(hit), 1);
        issue(4'd7, 0, 0);
        check("R2 read key", rdata, VA);

        issue(4'd3, 0, '1);
        issue(4'd9, 0, 0);
        check("R2 read don't-care B", rdata, '1);
        check("R7 B not yet selected", W'(hit_addr), 3);
        issue(4'd13, 0, 0);
        check("R7 all-ones B matches entry 0", W'(hit_addr), 0);
        issue(4'd12, 0, 0);
        check("R7 back to A", W'(hit_addr), 3);

        issue(4'd1, 0, 64'h5555_0000_0000_0000);
        check("R6 masked low byte agrees", W'(hit_addr), 4);
        issue(4'd6, 0, VG);
        check("R8 replaced entry no longer agrees", W'(hit), 0);
        issue(4'd10, 8'd4, 0);
        check("R8 entry 4 overwritten", rdata, VG);
        issue(4'd6, 0, VH);
        issue(4'd1, 0, VH);
        check("R8 write without agreement dropped", W'(hit), 0);
        check("R8 free unchanged", W'(free_addr), 6);

        issue(4'd1, 0, VD);
        issue(4'd11, 0, 0);
        check("R9 read agreeing entry", rdata, VD);
        issue(4'd1, 0, 64'h0123_0000_0000_0000);
        issue(4'd11, 0, 0);
        check("R9 no agreement reads zero", rdata, 0);

        for (int i = 0; i < 250; i++) issue(4'd5, 0, 64'h1000 + W'(i));
        check("R5 full after filling", W'(full), 1);
        check("R5 free_addr zero when full", W'(free_addr), 0);
        issue(4'd5, 0, VX);
        issue(4'd1, 0, VX);
        check("R5 write to free while full dropped", W'(hit), 0);
        issue(4'd4, 8'd200, VX);
        check("R3 indexed write while full", W'(hit_addr), 200);

        for (int i = 0; i < 400; i++) begin
            logic [3:0] o;
            o = 4'($urandom_range(0, 15));
            if (o == 4'd5) o = 4'd6;
            issue(o, AW'($urandom_range(0, 15)),
                  ($urandom_range(0, 1) != 0) ? 64'h1000 + W'($urandom_range(0, 7)) : VX);
        end

        live = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule